// File: doc/BRIEF.md
# Sequential Non-Restoring Divider

This block divides an unsigned 2N-bit dividend by an unsigned N-bit divisor. It yields an N-bit quotient and an N-bit remainder after N add-or-subtract iterations and one correction cycle. A partial remainder one bit wider than the divisor is shifted left together with the low half of the dividend.

In each iteration the block either adds the divisor or adds its two's complement. The choice follows the sign the partial remainder had after the previous iteration, and the first iteration always subtracts. The inverse of the new sign bit is shifted in as the next quotient bit. If the partial remainder is negative at the end, a single add of the divisor restores it.

A caller pulses `start` with both operands while the block is idle. It then waits for the one-cycle `done` pulse, which comes with the quotient, the remainder and an overflow flag. These outputs stay registered until the next completion. The results are only meaningful when the upper half of the dividend is below a non-zero divisor. In every other case the overflow flag is raised and the results are undefined.

Top module: `nrdiv_top`

## Requirements
- R1: While and right after reset, `busy`, `done`, `ovf`, `quotient` and `remainder` are all zero.
- R2: A `start` sampled high while `busy` is low is accepted. `busy` is high for exactly the N+1 cycles that follow the accepting edge and falls on the edge where `done` rises.
- R3: At `done`, `ovf` is 1 exactly when the accepted divisor is zero, or when the upper N bits of the accepted dividend are greater than or equal to the divisor.
- R4: At `done` with `ovf` low, `quotient` equals the integer quotient of the accepted dividend and divisor, and `remainder` equals their modulus.
- R5: `done` is high for exactly one cycle. It rises on the (N+1)th clock edge after the accepting edge.
- R6: A `start` raised while `busy` is high is ignored. Its operands do not affect the running result, and it produces no extra `done`.
- R7: At `done` with `ovf` low, the remainder is strictly below the divisor and quotient×divisor+remainder equals the dividend. This holds because of the final restore step.
- R8: `quotient`, `remainder` and `ovf` change only on the edge where `done` rises. Between completions they hold their values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Request a division; taken only while idle |
| dividend | input | 2N | Unsigned dividend, sampled with an accepted start |
| divisor | input | N | Unsigned divisor, sampled with an accepted start |
| busy | output | 1 | High while a division is in progress |
| done | output | 1 | One-cycle completion pulse |
| ovf | output | 1 | Result undefined: zero divisor or quotient too wide |
| quotient | output | N | Quotient of the last completed division |
| remainder | output | N | Remainder of the last completed division |

## Verification
`busy` is due one edge after the accepting edge, and `done` together with all three results is due N+1 edges after it. The driver samples on the falling edge that follows each of those rising edges. It checks that `done` stays low through the N iteration edges, is high after edge N+1, and is low again one edge later. The expected results are queued when the stimulus is applied and are popped by a monitor only on the falling edge where `done` is seen. A late, early or extra completion therefore shows up as a missing or surplus queue entry. A checker keeps its own edge counter from acceptance, so the latency holds for any N.

// File: rtl/nrdiv_pkg.sv
package nrdiv_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_FIX  = 2'd2
  } nrdiv_state_e;

endpackage

// File: rtl/nrdiv_addsub.sv
// Ripple adder that adds y (add=1) or the two's complement of y (add=0).
// Carry out of the top bit is dropped.
module nrdiv_addsub #(
  parameter int W = 5
) (
  input  logic [W-1:0] x,
  input  logic [W-1:0] y,
  input  logic         add,
  output logic [W-1:0] sum
);

  logic [W-1:0] yop;
  logic [W-1:0] c;

  assign yop  = y ^ {W{~add}};
  assign c[0] = ~add;

  for (genvar i = 0; i < W; i++) begin : g_bit
    assign sum[i] = x[i] ^ yop[i] ^ c[i];
    if (i < W - 1) begin : g_carry
      assign c[i+1] = (x[i] & yop[i]) | (c[i] & (x[i] ^ yop[i]));
    end
  end

endmodule

// File: rtl/nrdiv_ctrl.sv
module nrdiv_ctrl
  import nrdiv_pkg::*;
#(
  parameter int N = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  output logic load,
  output logic step,
  output logic fix,
  output logic busy,
  output logic done
);

  localparam int CW = (N > 2) ? $clog2(N) : 1;
  localparam logic [CW-1:0] LAST = CW'(N - 1);

  nrdiv_state_e state;
  logic [CW-1:0] cnt;

  assign load = (state == ST_IDLE) && start;
  assign step = (state == ST_RUN);
  assign fix  = (state == ST_FIX);

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= ST_IDLE;
      cnt   <= '0;
      busy  <= 1'b0;
      done  <= 1'b0;
    end else begin
      done <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          if (start) begin
            state <= ST_RUN;
            cnt   <= '0;
            busy  <= 1'b1;
          end
        end
        ST_RUN: begin
          if (cnt == LAST) state <= ST_FIX;
          else             cnt   <= cnt + 1'b1;
        end
        ST_FIX: begin
          state <= ST_IDLE;
          busy  <= 1'b0;
          done  <= 1'b1;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/nrdiv_datapath.sv
module nrdiv_datapath #(
  parameter int N = 4
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           load,
  input  logic           step,
  input  logic           fix,
  input  logic [2*N-1:0] dividend,
  input  logic [N-1:0]   divisor,
  output logic [N-1:0]   quotient,
  output logic [N-1:0]   remainder,
  output logic           ovf
);

  localparam int AW = N + 1;

  logic [AW-1:0] a_q;
  logic [N-1:0]  b_q;
  logic [N-1:0]  d_q;
  logic          k_q;
  logic          ovf_pend;

  logic [AW-1:0] a_sh;
  logic [AW-1:0] a_next;
  logic [N-1:0]  a_fixed;

  assign a_sh = {a_q[N-1:0], b_q[N-1]};

  nrdiv_addsub #(.W(AW)) u_step (
    .x   (a_sh),
    .y   ({1'b0, d_q}),
    .add (k_q),
    .sum (a_next)
  );

  nrdiv_addsub #(.W(N)) u_fix (
    .x   (a_q[N-1:0]),
    .y   (d_q),
    .add (1'b1),
    .sum (a_fixed)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      a_q       <= '0;
      b_q       <= '0;
      d_q       <= '0;
      k_q       <= 1'b0;
      ovf_pend  <= 1'b0;
      quotient  <= '0;
      remainder <= '0;
      ovf       <= 1'b0;
    end else if (load) begin
      a_q      <= {1'b0, dividend[2*N-1:N]};
      b_q      <= dividend[N-1:0];
      d_q      <= divisor;
      k_q      <= 1'b0;
      ovf_pend <= (divisor == '0) || (dividend[2*N-1:N] >= divisor);
    end else if (step) begin
      a_q <= a_next;
      b_q <= {b_q[N-2:0], ~a_next[N]};
      k_q <= a_next[N];
    end else if (fix) begin
      quotient  <= b_q;
      remainder <= a_q[N] ? a_fixed : a_q[N-1:0];
      ovf       <= ovf_pend;
    end
  end

endmodule

// File: rtl/nrdiv_top.sv
module nrdiv_top #(
  parameter int N = 4
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           start,
  input  logic [2*N-1:0] dividend,
  input  logic [N-1:0]   divisor,
  output logic           busy,
  output logic           done,
  output logic           ovf,
  output logic [N-1:0]   quotient,
  output logic [N-1:0]   remainder
);

  logic load, step, fix;

  nrdiv_ctrl #(.N(N)) u_ctrl (
    .clk   (clk),
    .rst   (rst),
    .start (start),
    .load  (load),
    .step  (step),
    .fix   (fix),
    .busy  (busy),
    .done  (done)
  );

  nrdiv_datapath #(.N(N)) u_dp (
    .clk       (clk),
    .rst       (rst),
    .load      (load),
    .step      (step),
    .fix       (fix),
    .dividend  (dividend),
    .divisor   (divisor),
    .quotient  (quotient),
    .remainder (remainder),
    .ovf       (ovf)
  );

endmodule

// File: rtl/nrdiv_chk.sv
module nrdiv_chk #(
  parameter int N = 4
) (
  input logic           clk,
  input logic           rst,
  input logic           start,
  input logic [2*N-1:0] dividend,
  input logic [N-1:0]   divisor,
  input logic           busy,
  input logic           done,
  input logic           ovf,
  input logic [N-1:0]   quotient,
  input logic [N-1:0]   remainder
);

  localparam int W  = 2 * N;
  localparam int CW = $clog2(N + 2) + 1;

  logic [W-1:0]  cap_dvd;
  logic [N-1:0]  cap_dvs;
  logic [CW-1:0] lat;
  logic          accept;

  assign accept = start && !busy;

  always_ff @(posedge clk) begin
    if (rst) begin
      cap_dvd <= '0;
      cap_dvs <= '0;
      lat     <= '0;
    end else if (accept) begin
      cap_dvd <= dividend;
      cap_dvs <= divisor;
      lat     <= '0;
    end else if (busy) begin
      lat <= lat + 1'b1;
    end
  end

  // R1
  p_reset_r1: assert property (@(posedge clk)
    rst |=> (!busy && !done && !ovf && quotient == '0 && remainder == '0));

  // R2
  p_busy_rise_r2: assert property (@(posedge clk) disable iff (rst)
    accept |=> busy);
  p_busy_done_r2: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);

  // R3
  p_no_overflow_r3: assert property (@(posedge clk) disable iff (rst)
    done |-> (ovf == ((cap_dvs == '0) || (cap_dvd[W-1:N] >= cap_dvs))));

  // R4, R7
  p_result_r4: assert property (@(posedge clk) disable iff (rst)
    (done && !ovf) |-> ((W'(quotient) * W'(cap_dvs) + W'(remainder)) == cap_dvd));
  p_rem_below_r7: assert property (@(posedge clk) disable iff (rst)
    (done && !ovf) |-> (remainder < cap_dvs));

  // R5
  p_done_pulse_r5: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  p_done_latency_r5: assert property (@(posedge clk) disable iff (rst)
    done |-> (lat == CW'(N + 1)));

  // R8
  p_hold_r8: assert property (@(posedge clk) disable iff (rst)
    !done |-> ($stable(quotient) && $stable(remainder) && $stable(ovf)));

endmodule

bind nrdiv_top nrdiv_chk #(.N(N)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .start     (start),
  .dividend  (dividend),
  .divisor   (divisor),
  .busy      (busy),
  .done      (done),
  .ovf       (ovf),
  .quotient  (quotient),
  .remainder (remainder)
);

// File: tb/nrdiv_top_bench.sv
`timescale 1ns/1ps
module nrdiv_top_bench;

  localparam int N = 4;
  localparam int W = 2 * N;

  typedef struct {
    logic [N-1:0] q;
    logic [N-1:0] r;
    logic [N-1:0] dvs;
    logic         ovf;
  } exp_t;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         start = 1'b0;
  logic [W-1:0] dividend = '0;
  logic [N-1:0] divisor = '0;
  logic         busy, done, ovf;
  logic [N-1:0] quotient, remainder;

  int checks = 0;
  int failures = 0;
  bit finished = 0;
  exp_t sb[$];

  always #2.5 clk = ~clk;

  nrdiv_top #(.N(N)) u_nrdiv_top (
    .clk(clk), .rst(rst), .start(start), .dividend(dividend), .divisor(divisor),
    .busy(busy), .done(done), .ovf(ovf), .quotient(quotient), .remainder(remainder)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic exp_t model(input logic [W-1:0] dvd, input logic [N-1:0] dvs);
    exp_t e;
    e.dvs = dvs;
    e.ovf = (dvs == '0) || (dvd[W-1:N] >= dvs);
    e.q = '0;
    e.r = '0;
    if (!e.ovf) begin
      e.q = N'(dvd / W'(dvs));
      e.r = N'(dvd % W'(dvs));
    end
    return e;
  endfunction

  // Monitor: pop one expected item per done pulse.
  always @(negedge clk) begin
    if (!rst && done) begin
      if (sb.size() == 0) begin
        chk(0, "R6", "done with empty queue", 1, 0);
      end else begin
        exp_t e;
        e = sb.pop_front();
        chk(ovf == e.ovf, "R3", "ovf", int'(ovf), int'(e.ovf));
        if (!e.ovf) begin
          chk(quotient == e.q, "R4", "quotient", int'(quotient), int'(e.q));
          chk(remainder == e.r, "R4", "remainder", int'(remainder), int'(e.r));
          chk(remainder < e.dvs, "R7", "remainder below divisor",
              int'(remainder), int'(e.dvs));
        end
      end
    end
  end

  task automatic run_op(input logic [W-1:0] dvd, input logic [N-1:0] dvs, input bit poke);
    exp_t e;
    e = model(dvd, dvs);
    @(negedge clk);
    start = 1'b1;
    dividend = dvd;
    divisor = dvs;
    sb.push_back(e);
    @(negedge clk);                 // after accepting edge
    start = 1'b0;
    chk(busy == 1'b1, "R2", "busy after start", int'(busy), 1);
    chk(done == 1'b0, "R5", "done early", int'(done), 0);
    if (poke) begin
      start = 1'b1;                 // R6: raised while busy
      dividend = ~dvd;
      divisor = dvs + 1'b1;
    end
    for (int i = 1; i <= N; i++) begin
      @(negedge clk);               // after edge i
      start = 1'b0;
      if (i < N + 1) begin
        chk(done == 1'b0, "R5", "done before latency", int'(done), 0);
        chk(busy == 1'b1, "R2", "busy during run", int'(busy), 1);
      end
    end
    @(negedge clk);                 // after edge N+1
    chk(done == 1'b1, "R5", "done at latency", int'(done), 1);
    chk(busy == 1'b0, "R2", "busy falls with done", int'(busy), 0);
    if (poke && !e.ovf) begin
      chk(quotient == e.q && remainder == e.r, "R6", "result after ignored start",
          int'({quotient, remainder}), int'({e.q, e.r}));
    end
    @(negedge clk);
    chk(done == 1'b0, "R5", "done pulse width", int'(done), 0);
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    chk(0, "R5", "watchdog expired", 0, 1);
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    // R1: reset state
    chk(busy == 0 && done == 0 && ovf == 0, "R1", "control outputs after reset",
        int'({busy, done, ovf}), 0);
    chk(quotient == 0 && remainder == 0, "R1", "results after reset",
        int'({quotient, remainder}), 0);

    // R4: worked example 181 / 14 -> q 12, r 13
    run_op(8'd181, 4'd14, 1'b0);
    // R8: results hold across idle cycles
    repeat (4) @(negedge clk);
    chk(quotient == 4'd12, "R8", "quotient held", int'(quotient), 12);
    chk(remainder == 4'd13, "R8", "remainder held", int'(remainder), 13);
    chk(ovf == 1'b0, "R8", "ovf held", int'(ovf), 0);

    // Exhaustive sweep, including zero divisor and overflow cases (R3, R4, R6)
    for (int dv = 0; dv < (1 << N); dv++) begin
      for (int dd = 0; dd < (1 << W); dd++) begin
        run_op(W'(dd), N'(dv), (dd % 7) == 3);
      end
    end

    repeat (4) @(negedge clk);
    chk(sb.size() == 0, "R5", "pending results", sb.size(), 0);
    finish_run();
  end

endmodule